// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector with Reference Fallback

This block runs on the recovered bit clock. It watches the serial data stream for transitions. When the stream stays flat for too long, it declares loss of signal, moves the clock source selection to the backup reference and drops the lock indication. An active-low external loss input from the optical module can also force the switchover. While that input is low in normal mode, the data passed downstream is held at zero. A loopback select takes the data from the diagnostic loopback input instead and ignores the external loss input.

Run lengths are measured coarsely. A free-running prescaler cuts time into blocks of 16 bit times, and a block counter counts the blocks that pass without a transition. The exact detection delay therefore depends on where the last transition fell inside its block. Leaving the fallback state needs the external loss input to be inactive and a transition in each of two consecutive blocks. The backup reference is the bit clock divided by eight, which is the reference frequency the synthesiser expects.

Top module: `lossdet_top`

## Requirements
- R1: In normal mode with the external loss input high, once the selected data stops toggling while the data source is selected, `useReference` rises between 96 and 120 bit times after the last transition.
- R2: While `loopbackEn` is 0 and `losInN` is 0, `dataOut` is 0 whatever `serialIn` does. Otherwise `dataOut` follows the selected input in the same cycle: `serialIn` when `loopbackEn` is 0 and `loopData` when it is 1.
- R3: When `losInN` goes low in normal mode while the data source is selected and the data is toggling, `useReference` rises between 64 and 96 bit times later.
- R4: `lockDet` is 1 only when the data source is selected (`useReference` = 0) and the block is not squelched. In normal mode, `losInN` = 0 forces `lockDet` to 0 in the same cycle.
- R5: With `loopbackEn` = 1, `losInN` has no effect. Toggling `loopData` selects the data source and holds `lockDet` at 1 even while `losInN` is 0.
- R6: Loss clears only while the block is not squelched and each of two consecutive 16-bit-time blocks has held a transition. A block with no transition, or any squelched cycle, restarts the count.
- R7: `refClkOut` is the bit clock divided by 8. It is low for 4 cycles and high for 4 cycles, free running from reset.
- R8: After reset, `useReference` = 1, `lockDet` = 0 and `refClkOut` = 0.
- R9: A transition restarts run-length measurement. Data that toggles at least once every 90 bit times keeps the data source selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Line serial data |
| loopData | input | 1 | Diagnostic loopback serial data |
| loopbackEn | input | 1 | 1 selects loopData and ignores losInN |
| losInN | input | 1 | External loss of signal, active low |
| dataOut | output | 1 | Selected, squelched serial data |
| useReference | output | 1 | 1 when the backup reference is the clock source |
| lockDet | output | 1 | Lock indication |
| refClkOut | output | 1 | Bit clock divided by 8 |

## Verification
The run-length expiry and the squelch expiry can both fire in the same cycle, and so can a recovery decision and the onset of squelch. The bench provokes the first case by stopping the data and then asserting the external loss input about 40 bit times later, so that both counters approach their limits in overlapping windows. It provokes the second by releasing and reasserting squelch around block boundaries during recovery. A behavioural model compares every output each cycle, judging which event wins: the model allows only one switchover, and it lets squelch veto any recovery.

// File: rtl/lossdet_pkg.sv
package lossdet_pkg;

  // Source selection: backup reference or recovered data
  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } srcState_t;

  // Strobes and flags from the datapath to the control
  typedef struct packed {
    logic squelch;        // external loss active in normal mode
    logic tick;           // last bit time of a prescaler block
    logic blockGood;      // block ending now held a transition
    logic runExpired;     // quiet-block limit reached
    logic squelchExpired; // squelch block limit reached
  } dpStatus_t;

endpackage

// File: rtl/lossdet_datapath.sv
module lossdet_datapath
  import lossdet_pkg::*;
#(
  parameter int BLOCK_LEN      = 16,
  parameter int LOSS_BLOCKS    = 7,
  parameter int SQUELCH_BLOCKS = 5,
  parameter int REF_DIV        = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serialIn,
  input  logic      loopData,
  input  logic      loopbackEn,
  input  logic      losInN,
  output logic      dataOut,
  output logic      refClkOut,
  output dpStatus_t status
);

  localparam int PS_W  = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int RUN_W = $clog2(LOSS_BLOCKS + 1);
  localparam int SQ_W  = $clog2(SQUELCH_BLOCKS + 1);
  localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [PS_W-1:0]  PS_LAST  = PS_W'(BLOCK_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(LOSS_BLOCKS);
  localparam logic [SQ_W-1:0]  SQ_LIM   = SQ_W'(SQUELCH_BLOCKS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(REF_DIV / 2);

  logic squelch;
  logic selBit;
  logic prevBit;
  logic edgeSeen;
  logic tick;
  logic hadEdge;
  logic [PS_W-1:0]  prescale;
  logic [RUN_W-1:0] runBlocks;
  logic [SQ_W-1:0]  sqBlocks;
  logic [DIV_W-1:0] divCnt;

  // Input selection and squelch
  assign squelch  = ~loopbackEn & ~losInN;
  assign selBit   = loopbackEn ? loopData : (serialIn & losInN);
  assign dataOut  = selBit;
  assign edgeSeen = selBit ^ prevBit;
  assign tick     = (prescale == PS_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBit <= 1'b0;
    else       prevBit <= selBit;
  end

  // Free-running block prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     prescale <= '0;
    else if (tick) prescale <= '0;
    else           prescale <= prescale + 1'b1;
  end

  // Quiet-block counter: a transition restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             runBlocks <= '0;
    else if (edgeSeen)                     runBlocks <= '0;
    else if (tick && runBlocks != RUN_LIM) runBlocks <= runBlocks + 1'b1;
  end

  // Transition-in-block flag for recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         hadEdge <= 1'b0;
    else if (tick)     hadEdge <= 1'b0;
    else if (edgeSeen) hadEdge <= 1'b1;
  end

  // Squelch duration counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sqBlocks <= '0;
    else if (!squelch)                  sqBlocks <= '0;
    else if (tick && sqBlocks != SQ_LIM) sqBlocks <= sqBlocks + 1'b1;
  end

  // Backup reference divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  assign refClkOut = (divCnt >= DIV_HALF);

  always_comb begin
    status                = '0;
    status.squelch        = squelch;
    status.tick           = tick;
    status.blockGood      = tick & (hadEdge | edgeSeen);
    status.runExpired     = (runBlocks == RUN_LIM);
    status.squelchExpired = (sqBlocks == SQ_LIM);
  end

  // Assertion support: cycles since the reference output last changed
  logic             prevRef;
  logic [DIV_W:0]   sinceFlip;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRef   <= 1'b0;
      sinceFlip <= '0;
    end else begin
      prevRef <= refClkOut;
      if (refClkOut != prevRef)  sinceFlip <= (DIV_W+1)'(1);
      else if (sinceFlip != '1)  sinceFlip <= sinceFlip + 1'b1;
    end
  end

  AST_REF_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (refClkOut != prevRef) |-> (sinceFlip == (DIV_W+1)'(REF_DIV / 2))); // R7

  AST_EDGE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> !status.runExpired); // R9

endmodule

// File: rtl/lossdet_control.sv
module lossdet_control
  import lossdet_pkg::*;
#(
  parameter int RECOVER_BLOCKS = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStatus_t status,
  output logic      useReference,
  output logic      lockDet
);

  localparam int GOOD_W = $clog2(RECOVER_BLOCKS + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RECOVER_BLOCKS - 1);

  srcState_t state, stateNext;
  logic [GOOD_W-1:0] goodBlocks, goodNext;

  always_comb begin
    stateNext = state;
    goodNext  = goodBlocks;
    case (state)
      SRC_DATA: begin
        if (status.runExpired || status.squelchExpired) begin
          stateNext = SRC_REF;
          goodNext  = '0;
        end
      end
      default: begin
        if (status.squelch) begin
          goodNext = '0;
        end else if (status.blockGood) begin
          if (goodBlocks == GOOD_LAST) begin
            stateNext = SRC_DATA;
            goodNext  = '0;
          end else begin
            goodNext = goodBlocks + 1'b1;
          end
        end else if (status.tick) begin
          goodNext = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SRC_REF;
      goodBlocks <= '0;
    end else begin
      state      <= stateNext;
      goodBlocks <= goodNext;
    end
  end

  assign useReference = (state == SRC_REF);
  assign lockDet      = (state == SRC_DATA) & ~status.squelch;

  AST_RUN_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRC_DATA && status.runExpired) |=> useReference); // R1

  AST_SQUELCH_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRC_DATA && status.squelchExpired) |=> useReference); // R3

  AST_CLEAN_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(useReference) |-> !$past(status.squelch)); // R6

  AST_RECOVER_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(useReference) |-> $past(status.blockGood)); // R6

endmodule

// File: rtl/lossdet_top.sv
module lossdet_top
  import lossdet_pkg::*;
#(
  parameter int BLOCK_LEN      = 16,
  parameter int LOSS_BLOCKS    = 7,
  parameter int SQUELCH_BLOCKS = 5,
  parameter int RECOVER_BLOCKS = 2,
  parameter int REF_DIV        = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic serialIn,
  input  logic loopData,
  input  logic loopbackEn,
  input  logic losInN,
  output logic dataOut,
  output logic useReference,
  output logic lockDet,
  output logic refClkOut
);

  dpStatus_t dpStatus;

  lossdet_datapath #(
    .BLOCK_LEN     (BLOCK_LEN),
    .LOSS_BLOCKS   (LOSS_BLOCKS),
    .SQUELCH_BLOCKS(SQUELCH_BLOCKS),
    .REF_DIV       (REF_DIV)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .loopData  (loopData),
    .loopbackEn(loopbackEn),
    .losInN    (losInN),
    .dataOut   (dataOut),
    .refClkOut (refClkOut),
    .status    (dpStatus)
  );

  lossdet_control #(
    .RECOVER_BLOCKS(RECOVER_BLOCKS)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .status      (dpStatus),
    .useReference(useReference),
    .lockDet     (lockDet)
  );

  AST_SQUELCH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!loopbackEn && !losInN) |-> (!dataOut && !lockDet)); // R2

  AST_LOCK_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    lockDet |-> !useReference); // R4

endmodule

// File: tb/lossdet_top_tb.sv
module lossdet_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialIn = 1'b0;
  logic loopData = 1'b0;
  logic loopbackEn = 1'b0;
  logic losInN = 1'b1;
  logic dataOut, useReference, lockDet, refClkOut;

  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lossdet_top u_dut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .loopData(loopData),
    .loopbackEn(loopbackEn), .losInN(losInN), .dataOut(dataOut),
    .useReference(useReference), .lockDet(lockDet), .refClkOut(refClkOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checkCount++;
    if (act < lo || act > hi) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Behavioural reference model, time measured in bit times
  int  phase;          // bit time inside the current 16-bit block
  int  quietBlocks;    // finished blocks since the last transition
  int  sqBlocksM;      // finished blocks while squelched
  int  goodRun;        // consecutive blocks holding a transition
  bit  blockHadEdge;
  bit  lastBit;
  bit  onRef;
  int  divPhase;

  function automatic bit modelData();
    if (loopbackEn) return loopData;
    return serialIn & losInN;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; quietBlocks = 0; sqBlocksM = 0; goodRun = 0;
      blockHadEdge = 0; lastBit = 0; onRef = 1; divPhase = 0;
    end else begin
      bit cur, sq, edgeNow, blockEnd, goodBlock;
      cur       = modelData();
      sq        = !loopbackEn && !losInN;
      edgeNow   = (cur != lastBit);
      blockEnd  = (phase == 15);
      goodBlock = blockEnd && (blockHadEdge || edgeNow);
      if (!onRef) begin
        if (quietBlocks >= 7 || sqBlocksM >= 5) begin onRef = 1; goodRun = 0; end
      end else if (sq) goodRun = 0;
      else if (goodBlock) begin
        goodRun++;
        if (goodRun >= 2) begin onRef = 0; goodRun = 0; end
      end else if (blockEnd) goodRun = 0;
      if (edgeNow) quietBlocks = 0;
      else if (blockEnd && quietBlocks < 7) quietBlocks++;
      if (!sq) sqBlocksM = 0;
      else if (blockEnd && sqBlocksM < 5) sqBlocksM++;
      if (blockEnd) blockHadEdge = 0; else if (edgeNow) blockHadEdge = 1;
      lastBit  = cur;
      phase    = (phase + 1) % 16;
      divPhase = (divPhase + 1) % 8;
    end
  end

  // Per-cycle comparison, 5 ns after the rising edge
  always begin
    @(posedge clk); #5;
    if (rstN && !done) begin
      check("R2 dataOut", dataOut, modelData());
      check("R1/R3/R6 useReference", useReference, onRef);
      check("R4/R5 lockDet", lockDet, !onRef && !(!loopbackEn && !losInN));
      check("R7 refClkOut", refClkOut, divPhase >= 4);
    end
  end

  task automatic toggleSer(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(negedge clk);
      serialIn = ~serialIn;
    end
  endtask

  task automatic toggleLoop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      loopData = ~loopData;
    end
  endtask

  // Counts rising edges until useReference is seen high
  task automatic waitRef(output int n);
    n = 0;
    while (n < 400) begin
      @(posedge clk); #5; n++;
      if (useReference) break;
    end
  endtask

  initial begin
    int lat;
    int hiCnt;
    repeat (3) @(negedge clk);
    #5;
    check("R8 reset useReference", useReference, 1);
    check("R8 reset lockDet", lockDet, 0);
    check("R8 reset refClkOut", refClkOut, 0);
    @(negedge clk); rstN = 1'b1;

    // Recovery with dense toggling
    toggleSer(80, 1);
    #5; check("R6 recovered", useReference, 0);
    check("R4 lock with data", lockDet, 1);

    // R9: sparse but frequent enough transitions keep data selected
    toggleSer(10, 90);
    #5; check("R9 stays on data", useReference, 0);

    // R1: stop toggling, measure run-length detection delay
    toggleSer(5, 1);
    waitRef(lat);
    checkRange("R1 loss latency", lat, 96, 120);

    // R6: transitions two and a half blocks apart never recover
    toggleSer(12, 40);
    #5; check("R6 sparse edges no recovery", useReference, 1);
    toggleSer(60, 1);
    #5; check("R6 recovery after dense edges", useReference, 0);

    // R3/R2: squelch while data toggles
    fork
      begin @(negedge clk); losInN = 1'b0; end
      toggleSer(200, 1);
      begin
        @(negedge clk); waitRef(lat);
        checkRange("R3 squelch latency", lat, 64, 96);
      end
    join
    #5; check("R2 squelched data", dataOut, 0);
    check("R4 lock low under squelch", lockDet, 0);

    // R6: data while squelched does not recover
    toggleSer(200, 1);
    #5; check("R6 squelch blocks recovery", useReference, 1);
    @(negedge clk); losInN = 1'b1;
    toggleSer(80, 1);
    #5; check("R6 recovery after squelch release", useReference, 0);

    // Coincidence: quiet data, squelch added 40 bit times later
    repeat (40) @(negedge clk);
    losInN = 1'b0;
    waitRef(lat);
    checkRange("R1/R3 coincident expiry", lat, 20, 90);
    repeat (30) @(negedge clk);
    losInN = 1'b1;
    // Squelch toggled around block ends during recovery
    for (int k = 0; k < 6; k++) begin
      toggleSer(12, 1);
      @(negedge clk); losInN = 1'b0;
      @(negedge clk); losInN = 1'b1;
    end
    toggleSer(80, 1);
    #5; check("R6 recovery after squelch pulses", useReference, 0);

    // R5: loopback ignores the external loss input
    @(negedge clk); loopbackEn = 1'b1; losInN = 1'b0;
    toggleLoop(300);
    #5; check("R5 loopback data selected", useReference, 0);
    check("R5 loopback lock held", lockDet, 1);
    check("R5 loopback data path", dataOut, loopData);

    // R7: measure high time of the reference output
    @(posedge refClkOut); hiCnt = 0;
    while (refClkOut) begin @(posedge clk); #1; hiCnt++; end
    check("R7 reference high time", hiCnt, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checkCount++; failCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule